// File: doc/BRIEF.md
# CAN fault confinement error counters

This block keeps the two error counters of a CAN controller and derives the node's fault confinement state from them. Upstream logic has already detected and classified each bus event, so the inputs are single-cycle pulses: transmit error, receive error, acknowledge error, good transmission and good reception. A separate strobe marks each sampled bus bit and carries its level. The block returns both counters, a 32-bit word that packs them for a register read, and a two-bit state code.

Weights are fixed. A transmit error adds 8 to the transmit counter and a receive error adds 1 to the receive counter. Each good frame takes 1 off its counter, and no counter goes below zero. The receive counter stops one step past the passive limit. The next good reception then pulls it back to a fixed reload value.

When the transmit counter would pass 255, the node goes bus-off and the transmit counter is cleared. In bus-off the transmit counter is reused to count groups of eleven consecutive recessive bits. When the group count reaches its target, the node returns to error-active with both counters cleared. All pins are plain level or pulse control signals. There is no data stream, so there is no valid/ready handshake and no back-pressure. A pulse is taken in the cycle it is high.

Top module: `can_fault_counters`

## Requirements
- R1: After reset both counters are 0 and the state code is 2'b00. The packed word always holds zero in bits 31:16, the receive counter in bits 15:8 and the transmit counter in bits 7:0.
- R2: Outside bus-off, a transmit error adds 8 to the transmit counter. A good transmission subtracts 1, but not below 0. If an error and a good transmission arrive in the same cycle, only the error counts.
- R3: Outside bus-off, a receive error adds 1 to the receive counter. A good reception subtracts 1, but not below 0. If both arrive in the same cycle, only the error counts.
- R4: While the receive counter is above 127, a receive error leaves it unchanged, so it never exceeds 128.
- R5: A good reception while the receive counter is above 127 (with no receive error in that cycle) loads 119.
- R6: The state code is 2'b01 (error-passive) when either counter is above 127 outside bus-off. Otherwise it is 2'b00 (error-active). Code 2'b11 never appears.
- R7: An acknowledge error adds 8 to the transmit counter while the state is 2'b00. It has no effect while the state is 2'b01.
- R8: A transmit-side error that would take the transmit counter above 255 enters bus-off: the state code becomes 2'b10 and the transmit counter is cleared. While bus-off holds, the error and success pulses change neither counter.
- R9: In bus-off, each strobed recessive bit (level 1) advances a run count. The 11th consecutive one clears the run and adds 1 to the transmit counter. A strobed dominant bit (level 0) clears the run and leaves the transmit counter unchanged.
- R10: When the recovery count would reach 128, the state returns to 2'b00 and both counters become 0.
- R11: Outside bus-off, bit strobes have no effect on either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_err_i | input | 1 | Transmit error pulse |
| rx_err_i | input | 1 | Receive error pulse |
| ack_err_i | input | 1 | Acknowledge error pulse |
| tx_ok_i | input | 1 | Good transmission pulse |
| rx_ok_i | input | 1 | Good reception pulse |
| bit_stb_i | input | 1 | Sampled-bit strobe |
| bit_rec_i | input | 1 | Bus level at the strobe, 1 = recessive |
| tec_o | output | 8 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| cnt_word_o | output | 32 | Packed counter word |
| fc_state_o | output | 2 | Fault confinement state code |

## Verification
Several kinds of update can land in the same clock cycle:
- a transmit error together with a good transmission;
- a receive error together with the reload of a saturated receive counter;
- a transmit error that enters bus-off while a receive event in the same cycle still updates the receive counter;
- an acknowledge error in the very cycle the node crosses into error-passive.

Directed steps assert these pulse pairs together on purpose, and a long random phase fires all pulses and strobes independently. A behavioural model applies the priority rules from the requirements, and every clock it is compared against all four outputs.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;

  function automatic fc_state_e fc_encode(input logic busoff, input logic passive);
    if (busoff)       return FC_BUSOFF;
    else if (passive) return FC_PASSIVE;
    else              return FC_ACTIVE;
  endfunction

endpackage

// File: rtl/can_busoff_recovery.sv
// Counts consecutive recessive sampled bits while bus-off is held and
// emits a one-cycle pulse each time a full run has been seen.
module can_busoff_recovery #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bit_stb_i,
  input  logic bit_rec_i,
  output logic group_o
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q;
  logic             at_last;

  assign at_last = (run_q == RUN_LAST);
  assign group_o = en_i && bit_stb_i && bit_rec_i && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!en_i) begin
      run_q <= '0;
    end else if (bit_stb_i) begin
      if (!bit_rec_i || at_last) run_q <= '0;
      else                       run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/can_tec_unit.sv
// Transmit error counter. Outside bus-off it holds the weighted error
// count; in bus-off it is reused as the recovery group counter.
module can_tec_unit #(
  parameter int CNT_W   = 8,
  parameter int STEP    = 8,
  parameter int GROUPS  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busoff_i,
  input  logic             err_i,
  input  logic             ok_i,
  input  logic             group_i,
  output logic             overflow_o,
  output logic             recovered_o,
  output logic [CNT_W-1:0] tec_o
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] GROUP_LAST = CNT_W'(GROUPS - 1);
  localparam logic [SUM_W-1:0] STEP_W     = SUM_W'(STEP);

  logic [CNT_W-1:0] tec_q;
  logic [SUM_W-1:0] sum;

  assign sum         = {1'b0, tec_q} + STEP_W;
  assign overflow_o  = !busoff_i && err_i && sum[CNT_W];
  assign recovered_o = busoff_i && group_i && (tec_q == GROUP_LAST);
  assign tec_o       = tec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
    end else if (busoff_i) begin
      if (group_i) begin
        if (recovered_o) tec_q <= '0;
        else             tec_q <= tec_q + 1'b1;
      end
    end else if (err_i) begin
      if (sum[CNT_W]) tec_q <= '0;
      else            tec_q <= sum[CNT_W-1:0];
    end else if (ok_i && (tec_q != '0)) begin
      tec_q <= tec_q - 1'b1;
    end
  end
endmodule

// File: rtl/can_rec_unit.sv
// Receive error counter with a saturating ceiling and a reload on the
// first good reception after saturation.
module can_rec_unit #(
  parameter int CNT_W  = 8,
  parameter int LIMIT  = 127,
  parameter int RELOAD = 119
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             clear_i,
  input  logic             err_i,
  input  logic             ok_i,
  output logic [CNT_W-1:0] rec_o
);
  localparam logic [CNT_W-1:0] LIMIT_W  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] RELOAD_W = CNT_W'(RELOAD);

  logic [CNT_W-1:0] rec_q;
  logic             sat;

  assign sat   = (rec_q > LIMIT_W);
  assign rec_o = rec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
    end else if (clear_i) begin
      rec_q <= '0;
    end else if (!hold_i) begin
      if (err_i) begin
        if (!sat) rec_q <= rec_q + 1'b1;
      end else if (ok_i) begin
        if (sat)                rec_q <= RELOAD_W;
        else if (rec_q != '0)   rec_q <= rec_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_fault_counters.sv
module can_fault_counters #(
  parameter int CNT_W        = 8,
  parameter int WORD_W       = 32,
  parameter int PASSIVE_LIM  = 127,
  parameter int TX_STEP      = 8,
  parameter int RUN_LEN      = 11,
  parameter int RECOV_GROUPS = 128,
  parameter int RX_RELOAD    = 119
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_err_i,
  input  logic              rx_err_i,
  input  logic              ack_err_i,
  input  logic              tx_ok_i,
  input  logic              rx_ok_i,
  input  logic              bit_stb_i,
  input  logic              bit_rec_i,
  output logic [CNT_W-1:0]  tec_o,
  output logic [CNT_W-1:0]  rec_o,
  output logic [WORD_W-1:0] cnt_word_o,
  output logic [1:0]        fc_state_o
);
  import can_fc_pkg::*;

  localparam int PAD_W = WORD_W - 2 * CNT_W;
  localparam logic [CNT_W-1:0] LIM_W = CNT_W'(PASSIVE_LIM);

  logic             busoff_q;
  logic             passive;
  logic             tx_fault;
  logic             group;
  logic             overflow;
  logic             recovered;
  logic [CNT_W-1:0] tec;
  logic [CNT_W-1:0] rec;

  assign passive  = (tec > LIM_W) || (rec > LIM_W);
  assign tx_fault = tx_err_i || (ack_err_i && !passive);

  can_busoff_recovery #(.RUN_LEN(RUN_LEN)) u_recov (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (busoff_q),
    .bit_stb_i (bit_stb_i),
    .bit_rec_i (bit_rec_i),
    .group_o   (group)
  );

  can_tec_unit #(.CNT_W(CNT_W), .STEP(TX_STEP), .GROUPS(RECOV_GROUPS)) u_tec (
    .clk         (clk),
    .rst_n       (rst_n),
    .busoff_i    (busoff_q),
    .err_i       (tx_fault),
    .ok_i        (tx_ok_i),
    .group_i     (group),
    .overflow_o  (overflow),
    .recovered_o (recovered),
    .tec_o       (tec)
  );

  can_rec_unit #(.CNT_W(CNT_W), .LIMIT(PASSIVE_LIM), .RELOAD(RX_RELOAD)) u_rec (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (busoff_q),
    .clear_i (recovered),
    .err_i   (rx_err_i),
    .ok_i    (rx_ok_i),
    .rec_o   (rec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busoff_q <= 1'b0;
    else if (overflow)  busoff_q <= 1'b1;
    else if (recovered) busoff_q <= 1'b0;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign cnt_word_o = {{PAD_W{1'b0}}, rec, tec};
    end else begin : g_nopad
      assign cnt_word_o = {rec, tec};
    end
  endgenerate

  assign tec_o      = tec;
  assign rec_o      = rec;
  assign fc_state_o = fc_encode(busoff_q, passive);
endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_err_i,
  input logic       rx_err_i,
  input logic       ack_err_i,
  input logic       tx_ok_i,
  input logic       rx_ok_i,
  input logic       bit_stb_i,
  input logic [7:0] tec_o,
  input logic [7:0] rec_o,
  input logic [1:0] fc_state_o
);
  p_state_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fc_state_o != 2'b11);

  p_rec_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_o <= 8'd128);

  p_tec_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state_o != 2'b10 && !tx_err_i && !ack_err_i && !tx_ok_i) |=> $stable(tec_o));

  p_rec_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state_o != 2'b10 && !rx_err_i && !rx_ok_i) |=> $stable(rec_o));

  p_ack_passive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state_o == 2'b01 && ack_err_i && !tx_err_i && !tx_ok_i) |=> $stable(tec_o));

  p_busoff_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state_o == 2'b10 && $past(fc_state_o) != 2'b10) |-> tec_o == 8'd0);

  p_busoff_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state_o == 2'b10 && !bit_stb_i) |=> ($stable(tec_o) && $stable(rec_o)));

  p_recover_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fc_state_o) == 2'b10 && fc_state_o != 2'b10) |-> (tec_o == 8'd0 && rec_o == 8'd0));
endmodule

bind can_fault_counters can_fc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_err_i   (tx_err_i),
  .rx_err_i   (rx_err_i),
  .ack_err_i  (ack_err_i),
  .tx_ok_i    (tx_ok_i),
  .rx_ok_i    (rx_ok_i),
  .bit_stb_i  (bit_stb_i),
  .tec_o      (tec_o),
  .rec_o      (rec_o),
  .fc_state_o (fc_state_o)
);

// File: tb/sim_can_fault_counters.sv
module sim_can_fault_counters;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_err = 1'b0, rx_err = 1'b0, ack_err = 1'b0;
  logic        tx_ok = 1'b0, rx_ok = 1'b0, bstb = 1'b0, brec = 1'b0;
  logic [7:0]  tec, rec;
  logic [31:0] word;
  logic [1:0]  st;

  int    checks = 0, errors = 0, cyc = 0;
  string cur = "R1";
  bit    done = 1'b0;

  int m_tec = 0, m_rec = 0, m_run = 0;
  bit m_boff = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fault_counters u0 (
    .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err), .rx_err_i(rx_err),
    .ack_err_i(ack_err), .tx_ok_i(tx_ok), .rx_ok_i(rx_ok),
    .bit_stb_i(bstb), .bit_rec_i(brec), .tec_o(tec), .rec_o(rec),
    .cnt_word_o(word), .fc_state_o(st)
  );

  // Behavioural reference model, updated on each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_tec = 0; m_rec = 0; m_run = 0; m_boff = 1'b0;
    end else if (m_boff) begin
      if (bstb) begin
        if (!brec) m_run = 0;
        else if (m_run == 10) begin
          m_run = 0;
          m_tec = m_tec + 1;
          if (m_tec == 128) begin
            m_boff = 1'b0; m_tec = 0; m_rec = 0;
          end
        end else m_run = m_run + 1;
      end
    end else begin
      bit passive, terr;
      passive = (m_tec > 127) || (m_rec > 127);
      terr = tx_err || (ack_err && !passive);
      if (terr) begin
        if (m_tec + 8 > 255) begin
          m_boff = 1'b1; m_tec = 0; m_run = 0;
        end else m_tec = m_tec + 8;
      end else if (tx_ok && m_tec > 0) m_tec = m_tec - 1;
      if (rx_err) begin
        if (m_rec <= 127) m_rec = m_rec + 1;
      end else if (rx_ok) begin
        if (m_rec > 127) m_rec = 119;
        else if (m_rec > 0) m_rec = m_rec - 1;
      end
    end
  end

  function automatic int exp_state();
    if (m_boff) return 2;
    if (m_tec > 127 || m_rec > 127) return 1;
    return 0;
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", cur, what, act, exp, cyc);
    end
  endtask

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("tec", int'(tec), m_tec);
      chk("rec", int'(rec), m_rec);
      chk("state", int'(st), exp_state());
      chk("word R1", int'(word), (m_rec << 8) | m_tec);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(bit te, bit re, bit ae, bit to, bit ro, bit sb, bit rb);
    @(negedge clk);
    #1;
    tx_err = te; rx_err = re; ack_err = ae; tx_ok = to; rx_ok = ro; bstb = sb; brec = rb;
  endtask

  task automatic rep(int n, bit te, bit re, bit ae, bit to, bit ro, bit sb, bit rb);
    for (int i = 0; i < n; i++) step(te, re, ae, to, ro, sb, rb);
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic snap(string req, int et, int er, int es);
    @(negedge clk);
    cur = req;
    chk("tec direct", int'(tec), et);
    chk("rec direct", int'(rec), er);
    chk("state direct", int'(st), es);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur = "R1";
    snap("R1", 0, 0, 0);
    chk("word high R1", int'(word[31:16]), 0);

    cur = "R11";
    rep(30, 0, 0, 0, 0, 0, 1, 1);
    snap("R11", 0, 0, 0);

    cur = "R2";
    rep(5, 1, 0, 0, 0, 0, 0, 0);
    snap("R2", 40, 0, 0);
    rep(3, 1, 0, 0, 1, 0, 0, 0);
    snap("R2", 64, 0, 0);
    rep(70, 0, 0, 0, 1, 0, 0, 0);
    snap("R2", 0, 0, 0);

    cur = "R3";
    rep(4, 0, 1, 0, 0, 0, 0, 0);
    rep(2, 0, 1, 0, 0, 1, 0, 0);
    snap("R3", 0, 6, 0);
    rep(9, 0, 0, 0, 0, 1, 0, 0);
    snap("R3", 0, 0, 0);
    chk("word R1", int'(word), 0);

    cur = "R7";
    rep(16, 0, 0, 1, 0, 0, 0, 0);
    snap("R6", 128, 0, 1);
    cur = "R7";
    rep(6, 0, 0, 1, 0, 0, 0, 0);
    snap("R7", 128, 0, 1);
    rep(1, 0, 0, 0, 1, 0, 0, 0);
    snap("R6", 127, 0, 0);
    cur = "R7";
    rep(1, 0, 0, 1, 0, 0, 0, 0);
    snap("R7", 135, 0, 1);
    rep(140, 0, 0, 0, 1, 0, 0, 0);

    cur = "R4";
    rep(135, 0, 1, 0, 0, 0, 0, 0);
    snap("R4", 0, 128, 1);
    rep(1, 0, 1, 0, 0, 1, 0, 0);
    snap("R4", 0, 128, 1);
    chk("word R1", int'(word), 128 << 8);
    cur = "R5";
    rep(1, 0, 0, 0, 0, 1, 0, 0);
    snap("R5", 0, 119, 0);
    rep(5, 0, 1, 0, 0, 0, 0, 0);

    cur = "R8";
    rep(31, 1, 0, 0, 0, 0, 0, 0);
    snap("R8", 248, 124, 1);
    rep(1, 1, 1, 0, 0, 0, 0, 0);
    snap("R8", 0, 125, 2);
    rep(20, 1, 1, 1, 1, 1, 0, 0);
    snap("R8", 0, 125, 2);

    cur = "R9";
    for (int k = 0; k < 4; k++) begin
      rep(10, 0, 0, 0, 0, 0, 1, 1);
      rep(1, 0, 0, 0, 0, 0, 1, 0);
    end
    snap("R9", 0, 125, 2);
    rep(11, 0, 0, 0, 0, 0, 1, 1);
    snap("R9", 1, 125, 2);
    rep(25, 0, 0, 0, 0, 0, 1, 1);
    snap("R9", 3, 125, 2);

    cur = "R10";
    for (int k = 0; k < 124; k++) rep(11, 0, 0, 0, 0, 0, 1, 1);
    rep(1, 0, 0, 0, 0, 0, 1, 0);
    snap("R10", 127, 125, 2);
    rep(10, 0, 0, 0, 0, 0, 1, 1);
    snap("R10", 127, 125, 2);
    rep(1, 0, 0, 0, 0, 0, 1, 1);
    snap("R10", 0, 0, 0);

    cur = "R8";
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 12, $urandom_range(0, 9) < 2, $urandom_range(0, 9) < 2,
           $urandom_range(0, 9) < 1, $urandom_range(0, 9) < 1,
           $urandom_range(0, 9) < 8, $urandom_range(0, 99) < 97);
    end
    step(0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule